// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte mailbox between a host bus and the local processor of a PC-AT style keyboard controller. The host sees two addresses, chosen by one address-select input: the data address and the command/status address. A host write to either address drops a byte into the input buffer and raises the input-full flag. The block records in a command/data flag which address the byte was written to.

The local processor answers through the output buffer. Loading the output buffer raises the output-full flag and, if enabled, the keyboard interrupt toward the host. A host read of the data address collects that byte and drops both the flag and the interrupt. A host read of the command address returns the status byte and has no side effect. The local processor can also set the user-defined status bits. It receives an input-full interrupt request that it can mask.

Top module: `kbc_host_mailbox`

## Requirements
- R1: After reset the status byte, the keyboard interrupt and the input-full interrupt request are all 0.
- R2: A host write (chip select and write strobe high) to either address loads the input buffer and sets input-full (status bit 1), visible from the next cycle.
- R3: Status bit 3 (command/data) takes the value of the address-select input of the most recent host write: 1 marks a command, 0 marks data.
- R4: The local input-buffer read port always presents the input buffer. A local read strobe clears input-full from the next cycle.
- R5: When a host write and a local read strobe fall in the same cycle, input-full ends set and the buffer holds the new byte.
- R6: A local output-buffer write loads the output buffer and sets output-full (status bit 0). The keyboard interrupt is set only if its enable input is high in that cycle.
- R7: A host read with address-select 0 returns the output buffer in the same cycle and clears output-full and the keyboard interrupt from the next cycle.
- R8: A host read with address-select 1 returns the status byte, laid out as bit 0 output-full, bit 1 input-full, bit 3 command/data and bits 2, 4, 5, 6, 7 user-defined. This read changes no state.
- R9: A local status write updates only bits 2 and 4 to 7 from its data. The flag bits are unaffected, and the host has no path to write the status byte.
- R10: The input-full interrupt request equals input-full ANDed with its local enable input.
- R11: When a local output-buffer write and a host data read fall in the same cycle, output-full ends set with the new byte.
- R12: Read and write strobes with chip select low have no effect, and the host read data is 0 outside a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host chip select |
| host_sel | input | 1 | Address select: 1 command/status, 0 data |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| cpu_obuf_wr | input | 1 | Local write of the output buffer |
| cpu_obuf_wdata | input | 8 | Byte for the output buffer |
| cpu_ibuf_rd | input | 1 | Local read strobe of the input buffer |
| cpu_ibuf_rdata | output | 8 | Input buffer contents |
| cpu_stat_wr | input | 1 | Local write of the user-defined status bits |
| cpu_stat_wdata | input | 8 | Status write byte (bits 2, 4-7 used) |
| cpu_status | output | 8 | Status byte as seen by the local processor |
| kirq_en | input | 1 | Keyboard interrupt enable |
| ibfi_en | input | 1 | Input-full interrupt enable |
| kirq | output | 1 | Keyboard interrupt to the host |
| ibf_irq | output | 1 | Input-full interrupt request to the local processor |

## Verification
The read paths, both host read data and the local input-buffer port, are combinational and are due in the same cycle as the strobe. The bench compares them about 1 ns after it drives the inputs, before the edge. Flags, the command/data bit, the user bits and the keyboard interrupt pass through one register and are due in the cycle after the strobe. The input-full request follows input-full with no further delay. The bench model updates its state only after each rising edge, so every comparison at the following falling edge lines up with that single register stage. Same-cycle collisions are driven on purpose to pin the write-wins rules.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int DATA_W  = 8;
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int CD_BIT  = 3;
    localparam logic [DATA_W-1:0] UD_MASK = 8'hF4;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ibf;
        logic              cd;
    } in_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              obf;
        logic              kirq;
    } out_state_t;
endpackage

// File: rtl/kbc_in_path.sv
module kbc_in_path
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_stb,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cpu_rd_stb,
    output logic [DATA_W-1:0] ibuf,
    output logic              ibf,
    output logic              cd
);
    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_rd_stb) st_d.ibf = 1'b0;
        // host write has priority over the local clear
        if (host_wr_stb) begin
            st_d.data = host_wdata;
            st_d.ibf  = 1'b1;
            st_d.cd   = host_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ibuf = st_q.data;
    assign ibf  = st_q.ibf;
    assign cd   = st_q.cd;

    // R2 R5
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_stb |=> (ibf && ibuf == $past(host_wdata)));
    // R4
    ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_stb && !host_wr_stb) |=> !ibf);
    // R3
    cd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_stb |=> (cd == $past(host_sel)));
endmodule

// File: rtl/kbc_out_path.sv
module kbc_out_path
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_data,
    input  logic              kirq_en,
    input  logic              host_rd_stb,
    output logic [DATA_W-1:0] obuf,
    output logic              obf,
    output logic              kirq
);
    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_rd_stb) begin
            st_d.obf  = 1'b0;
            st_d.kirq = 1'b0;
        end
        // a fresh load wins over a host collect in the same cycle
        if (load_stb) begin
            st_d.data = load_data;
            st_d.obf  = 1'b1;
            if (kirq_en) st_d.kirq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign obuf = st_q.data;
    assign obf  = st_q.obf;
    assign kirq = st_q.kirq;

    // R6 R11
    obf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (obf && obuf == $past(load_data)));
    // R7
    obf_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stb && !load_stb) |=> (!obf && !kirq));
    // R6
    kirq_needs_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kirq |-> obf);
endmodule

// File: rtl/kbc_status.sv
module kbc_status
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ud_wr,
    input  logic [DATA_W-1:0] ud_wdata,
    input  logic              obf,
    input  logic              ibf,
    input  logic              cd,
    input  logic              ibfi_en,
    output logic [DATA_W-1:0] status,
    output logic              ibf_irq
);
    logic [DATA_W-1:0] ud_d, ud_q;

    always_comb begin
        ud_d = ud_q;
        if (ud_wr) ud_d = ud_wdata & UD_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ud_q <= '0;
        else        ud_q <= ud_d;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == OBF_BIT) begin : g_obf
            assign status[i] = obf;
        end else if (i == IBF_BIT) begin : g_ibf
            assign status[i] = ibf;
        end else if (i == CD_BIT) begin : g_cd
            assign status[i] = cd;
        end else begin : g_ud
            assign status[i] = ud_q[i];
        end
    end

    assign ibf_irq = ibf & ibfi_en;

    // R9
    ud_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ud_wr |=> $stable(status & UD_MASK));
    // R9
    ud_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ud_wr |=> ((status & UD_MASK) == ($past(ud_wdata) & UD_MASK)));
endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cpu_obuf_wr,
    input  logic [DATA_W-1:0] cpu_obuf_wdata,
    input  logic              cpu_ibuf_rd,
    output logic [DATA_W-1:0] cpu_ibuf_rdata,
    input  logic              cpu_stat_wr,
    input  logic [DATA_W-1:0] cpu_stat_wdata,
    output logic [DATA_W-1:0] cpu_status,
    input  logic              kirq_en,
    input  logic              ibfi_en,
    output logic              kirq,
    output logic              ibf_irq
);
    logic              hw_stb, hrd_data, hrd_stat;
    logic [DATA_W-1:0] obuf, status;
    logic              ibf, obf, cd;

    assign hw_stb   = host_cs & host_wr;
    assign hrd_data = host_cs & host_rd & ~host_sel;
    assign hrd_stat = host_cs & host_rd &  host_sel;

    kbc_in_path u_in (
        .clk(clk), .rst_n(rst_n), .host_wr_stb(hw_stb), .host_sel(host_sel),
        .host_wdata(host_wdata), .cpu_rd_stb(cpu_ibuf_rd),
        .ibuf(cpu_ibuf_rdata), .ibf(ibf), .cd(cd)
    );

    kbc_out_path u_out (
        .clk(clk), .rst_n(rst_n), .load_stb(cpu_obuf_wr), .load_data(cpu_obuf_wdata),
        .kirq_en(kirq_en), .host_rd_stb(hrd_data),
        .obuf(obuf), .obf(obf), .kirq(kirq)
    );

    kbc_status u_stat (
        .clk(clk), .rst_n(rst_n), .ud_wr(cpu_stat_wr), .ud_wdata(cpu_stat_wdata),
        .obf(obf), .ibf(ibf), .cd(cd), .ibfi_en(ibfi_en),
        .status(status), .ibf_irq(ibf_irq)
    );

    always_comb begin
        host_rdata = '0;
        if (hrd_data)      host_rdata = obuf;
        else if (hrd_stat) host_rdata = status;
    end

    assign cpu_status = status;

    // R8
    stat_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hrd_stat && !hw_stb && !cpu_obuf_wr && !cpu_ibuf_rd && !cpu_stat_wr)
        |=> $stable(status));
    // R12
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs && !cpu_obuf_wr && !cpu_ibuf_rd && !cpu_stat_wr)
        |=> ($stable(status) && $stable(kirq)));
endmodule

// File: tb/sim_kbc_host_mailbox.sv
module sim_kbc_host_mailbox;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cs = 0, host_sel = 0, host_rd = 0, host_wr = 0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic cpu_obuf_wr = 0, cpu_ibuf_rd = 0, cpu_stat_wr = 0;
    logic [7:0] cpu_obuf_wdata = '0, cpu_ibuf_rdata, cpu_stat_wdata = '0, cpu_status;
    logic kirq_en = 0, ibfi_en = 0, kirq, ibf_irq;

    int vectors = 0, fails = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_ibuf = 0, m_obuf = 0, m_ud = 0;
    logic m_ibf = 0, m_obf = 0, m_cd = 0, m_kirq = 0;

    always #5 clk = ~clk;

    kbc_host_mailbox u0 (.*);

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return (m_ud & 8'hF4) | {4'b0, m_cd, 1'b0, m_ibf, m_obf};
    endfunction

    task automatic step(input logic cs, rd, wr, sel, input logic [7:0] hd,
                        input logic ow, input logic [7:0] od, input logic ir,
                        input logic sw, input logic [7:0] sd, input string tag);
        logic [7:0] exp_rd;
        host_cs = cs; host_rd = rd; host_wr = wr; host_sel = sel; host_wdata = hd;
        cpu_obuf_wr = ow; cpu_obuf_wdata = od; cpu_ibuf_rd = ir;
        cpu_stat_wr = sw; cpu_stat_wdata = sd;
        #1;
        exp_rd = (cs && rd) ? (sel ? m_status() : m_obuf) : 8'h00;
        cmp(tag, "host_rdata", host_rdata, exp_rd);
        cmp(tag, "cpu_ibuf_rdata", cpu_ibuf_rdata, m_ibuf);
        cmp(tag, "status", cpu_status, m_status());
        cmp(tag, "kirq", {7'b0, kirq}, {7'b0, m_kirq});
        cmp(tag, "ibf_irq", {7'b0, ibf_irq}, {7'b0, m_ibf & ibfi_en});
        @(posedge clk);
        if (ir) m_ibf = 0;
        if (cs && wr) begin m_ibuf = hd; m_ibf = 1; m_cd = sel; end
        if (cs && rd && !sel) begin m_obf = 0; m_kirq = 0; end
        if (ow) begin m_obuf = od; m_obf = 1; if (kirq_en) m_kirq = 1; end
        if (sw) m_ud = sd & 8'hF4;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'h00, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        kirq_en = 1; ibfi_en = 1;
        step(1, 0, 1, 0, 8'h5A, 0, 0, 0, 0, 0, "R2"); idle("R2"); idle("R10");
        step(1, 0, 1, 1, 8'hD1, 0, 0, 0, 0, 0, "R3"); idle("R3");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R4"); idle("R4");
        step(0, 0, 0, 0, 0, 1, 8'h3C, 0, 0, 0, "R6"); idle("R6");
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R8"); step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7"); idle("R7");
        kirq_en = 0;
        step(0, 0, 0, 0, 0, 1, 8'h77, 0, 0, 0, "R6"); idle("R6");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7"); idle("R7");
        kirq_en = 1;
        step(1, 0, 1, 0, 8'hA5, 0, 0, 1, 0, 0, "R5"); idle("R5");
        step(0, 0, 0, 0, 0, 1, 8'h11, 0, 0, 0, "R11");
        step(1, 1, 0, 0, 0, 1, 8'h22, 0, 0, 0, "R11"); idle("R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, "R9"); idle("R9");
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h0B, "R9"); idle("R9");
        ibfi_en = 0; idle("R10"); ibfi_en = 1; idle("R10");
        step(0, 1, 1, 0, 8'hEE, 0, 0, 0, 0, 0, "R12"); idle("R12");
        step(0, 1, 0, 1, 8'h00, 0, 0, 0, 0, 0, "R12"); idle("R12");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            kirq_en = r[10]; ibfi_en = r[11];
            step(r[0], r[1] & ~r[2], r[2], r[3], r[19:12], r[4], r[27:20],
                 r[5], r[6], r[31:24], "R2");
        end
        finish_run();
    end
endmodule